// File: doc/BRIEF.md
# Debug Show Cycle Bus Control

This block decides what the external bus pins carry while the processor talks to its own on-chip peripherals. Such accesses never need the external bus. For debugging, a 2-bit enable field can make them visible: the address, function code, size and direction lines always show the internal access, and when the field is nonzero the data strobe and the data bus also show it. The external address strobe stays negated for every internal access, so a logic analyzer can tell these mirrored accesses apart from real external ones.

An internal access is marked by a one-clock start pulse and a one-clock end pulse. The block takes the attributes on the start pulse and holds them on the pins until the next access. It also fixes, at that same edge, whether the access is mirrored. While a mirrored access is open, the data strobe is asserted and the data bus is driven. A write shows its write data. A read shows the peripheral's read data, sampled on every clock.

Top module: `show_cycle_ctrl`

## Requirements
- R1: While reset is low and on the first clock after it, cfg_rd_data is 0, ext_as_n and ext_ds_n are 1, ext_data_oe is 0, ext_data_out is 0 and ext_addr, ext_fc, ext_size and ext_rnw are 0.
- R2: A clock with cfg_wr_en high loads cfg_wr_data into the 2-bit enable field, and cfg_rd_data shows it from the next clock on. Without cfg_wr_en the field keeps its value. Value 00 disables mirroring; 01, 10 and 11 enable it.
- R3: A start pulse seen while no access is open copies int_addr, int_fc, int_size and int_rnw to the external lines on that clock edge, whatever the enable field holds. The lines then hold those values until the next accepted start.
- R4: ext_as_n is 1 at all times.
- R5: If the field was 00 at the accepted start, ext_ds_n stays 1, ext_data_oe stays 0 and ext_data_out stays 0 for the whole access.
- R6: If the field was nonzero at the accepted start, ext_ds_n goes to 0 on that clock edge. It returns to 1 on the edge where the end pulse is seen.
- R7: ext_data_oe is 1 exactly when ext_data_strobe is asserted (ext_ds_n is 0), and ext_data_out is 0 whenever ext_data_oe is 0.
- R8: In a mirrored write (int_rnw 0), ext_data_out carries int_wdata as sampled at the start edge, and later changes of int_wdata do not alter it.
- R9: In a mirrored read (int_rnw 1), ext_data_out carries int_rdata as sampled on the previous clock edge while the access is open.
- R10: A write to the enable field during an open access does not change whether that access is mirrored.
- R11: If start and end arrive on the same clock, an enabled access asserts ext_ds_n for exactly one clock.
- R12: A start pulse that arrives while an access is open is ignored: the external attribute lines keep their values and the open access is not extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the enable field |
| cfg_wr_data | input | 2 | New enable field value |
| cfg_rd_data | output | 2 | Current enable field value |
| int_start | input | 1 | One-clock pulse: internal access begins |
| int_end | input | 1 | One-clock pulse: internal access completes |
| int_addr | input | ADDR_W | Internal access address |
| int_fc | input | FC_W | Internal function code |
| int_size | input | SIZE_W | Internal transfer size |
| int_rnw | input | 1 | Internal direction, 1 = read |
| int_wdata | input | DATA_W | Internal write data |
| int_rdata | input | DATA_W | Read data returned by the internal peripheral |
| ext_as_n | output | 1 | External address strobe, active low |
| ext_ds_n | output | 1 | External data strobe, active low |
| ext_addr | output | ADDR_W | External address lines |
| ext_fc | output | FC_W | External function code lines |
| ext_size | output | SIZE_W | External size lines |
| ext_rnw | output | 1 | External direction line |
| ext_data_out | output | DATA_W | Value for the external data bus |
| ext_data_oe | output | 1 | Data bus output enable |

## Verification
The access tracker holds the mirrored or hidden mode of each access. If that state is wrong, the strobe and output enable show it on the first clock after the start pulse. A tracker stuck open or closed shows one clock after the end pulse: the strobe stays low too long or the next start is ignored. A wrong attribute or data capture shows on the pins on the clock after the faulty edge. Because the bench compares every output on every clock, each such fault appears within one cycle.

// File: rtl/sc_show_pkg.sv
// Shared types for the show cycle bus control.
// Assumes: nothing beyond the standard; pure type package.
package sc_show_pkg;
    // Phase of the internal access as seen by the external pins.
    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,   // no internal access open
        CYC_SHOW = 2'd1,   // access open, mirrored onto the pins
        CYC_HIDE = 2'd2    // access open, strobes kept quiet
    } cyc_state_e;
endpackage

// File: rtl/sc_show_cfg.sv
// Show-enable configuration field.
// Holds the CFG_W-bit enable field behind a simple write/read port and
// reports whether mirroring is currently requested (any nonzero value).
// Assumes: a single writer; writes take effect on the next clock.
module sc_show_cfg #(
    parameter int CFG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic             show_en
);
    logic [CFG_W-1:0] field_q;

    // Purpose: load the field on a write; clear it (mirroring off) on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
        end else if (wr_en) begin
            field_q <= wr_data;
        end
    end

    assign rd_data = field_q;
    assign show_en = |field_q;

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data)); // R2
    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data)); // R2
endmodule

// File: rtl/sc_cycle_track.sv
// Internal access tracker.
// Opens an access on a start pulse when idle, fixes its mirrored/hidden
// mode at that edge, and closes it on the end pulse (or one clock later
// when start and end coincide).
// Assumes: int_start and int_end are single-clock pulses; starts seen
// while an access is open are not new accesses.
module sc_cycle_track
    import sc_show_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic int_start,
    input  logic int_end,
    input  logic show_en,
    output logic cyc_open,
    output logic cyc_busy,
    output logic cyc_show
);
    cyc_state_e state_q;
    logic       last_q;   // end already seen on the start clock

    // Purpose: advance the access phase on start and end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            last_q  <= 1'b0;
        end else begin
            case (state_q)
                CYC_IDLE: begin
                    if (int_start) begin
                        state_q <= show_en ? CYC_SHOW : CYC_HIDE;
                        last_q  <= int_end;
                    end
                end
                default: begin
                    if (int_end || last_q) begin
                        state_q <= CYC_IDLE;
                        last_q  <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign cyc_open = (state_q == CYC_IDLE) && int_start;
    assign cyc_busy = (state_q != CYC_IDLE);
    assign cyc_show = (state_q == CYC_SHOW);

    AST_OPEN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_open |=> cyc_busy); // R6
    AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_busy && int_end) |=> !cyc_busy); // R6
    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_busy |=> (!cyc_busy || $stable(cyc_show))); // R10
    AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_open && int_end) |=> (cyc_busy ##1 !cyc_busy)); // R11
endmodule

// File: rtl/sc_pin_drive.sv
// External pin driver for internal accesses.
// Latches the access attributes on every accepted start, holds the data
// shown on the bus, and forms the data strobe and output enable.
// Assumes: cyc_open/cyc_busy/cyc_show come from sc_cycle_track.
module sc_pin_drive #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int FC_W   = 3,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_open,
    input  logic              cyc_busy,
    input  logic              cyc_show,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic [FC_W-1:0]   int_fc,
    input  logic [SIZE_W-1:0] int_size,
    input  logic              int_rnw,
    input  logic [DATA_W-1:0] int_wdata,
    input  logic [DATA_W-1:0] int_rdata,
    output logic              ext_ds_n,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [FC_W-1:0]   ext_fc,
    output logic [SIZE_W-1:0] ext_size,
    output logic              ext_rnw,
    output logic [DATA_W-1:0] ext_data_out,
    output logic              ext_data_oe
);
    logic [ADDR_W-1:0] addr_q;
    logic [FC_W-1:0]   fc_q;
    logic [SIZE_W-1:0] size_q;
    logic              rnw_q;
    logic [DATA_W-1:0] data_q;

    // Purpose: capture attributes of each accepted access, mirrored or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            fc_q   <= '0;
            size_q <= '0;
            rnw_q  <= 1'b0;
        end else if (cyc_open) begin
            addr_q <= int_addr;
            fc_q   <= int_fc;
            size_q <= int_size;
            rnw_q  <= int_rnw;
        end
    end

    // Purpose: hold write data from the start edge, track read data each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cyc_open) begin
            data_q <= int_rnw ? int_rdata : int_wdata;
        end else if (cyc_busy && rnw_q) begin
            data_q <= int_rdata;
        end
    end

    assign ext_addr     = addr_q;
    assign ext_fc       = fc_q;
    assign ext_size     = size_q;
    assign ext_rnw      = rnw_q;
    assign ext_ds_n     = ~cyc_show;
    assign ext_data_oe  = cyc_show;
    assign ext_data_out = cyc_show ? data_q : '0;

    AST_ATTR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_open |=> (ext_addr == $past(int_addr) && ext_rnw == $past(int_rnw))); // R3
    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_open |=> ($stable(ext_addr) && $stable(ext_fc) && $stable(ext_size))); // R12
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_show && !ext_rnw && !cyc_open) |=> (!ext_data_oe || $stable(ext_data_out))); // R8
    AST_RDATA_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_busy && ext_rnw) |=> (!ext_data_oe || ext_data_out == $past(int_rdata))); // R9
endmodule

// File: rtl/show_cycle_ctrl.sv
// Show cycle bus control, top level.
// Mirrors internal peripheral accesses onto the external pins for debug:
// attributes always, strobe and data only while the enable field is set.
// The address strobe is never asserted for an internal access.
// Assumes: one internal access at a time, framed by start/end pulses.
module show_cycle_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int FC_W   = 3,
    parameter int SIZE_W = 2,
    parameter int CFG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic              int_start,
    input  logic              int_end,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic [FC_W-1:0]   int_fc,
    input  logic [SIZE_W-1:0] int_size,
    input  logic              int_rnw,
    input  logic [DATA_W-1:0] int_wdata,
    input  logic [DATA_W-1:0] int_rdata,
    output logic              ext_as_n,
    output logic              ext_ds_n,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [FC_W-1:0]   ext_fc,
    output logic [SIZE_W-1:0] ext_size,
    output logic              ext_rnw,
    output logic [DATA_W-1:0] ext_data_out,
    output logic              ext_data_oe
);
    logic show_en;
    logic cyc_open;
    logic cyc_busy;
    logic cyc_show;

    sc_show_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .show_en (show_en)
    );

    sc_cycle_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_start (int_start),
        .int_end   (int_end),
        .show_en   (show_en),
        .cyc_open  (cyc_open),
        .cyc_busy  (cyc_busy),
        .cyc_show  (cyc_show)
    );

    sc_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FC_W   (FC_W),
        .SIZE_W (SIZE_W)
    ) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_open     (cyc_open),
        .cyc_busy     (cyc_busy),
        .cyc_show     (cyc_show),
        .int_addr     (int_addr),
        .int_fc       (int_fc),
        .int_size     (int_size),
        .int_rnw      (int_rnw),
        .int_wdata    (int_wdata),
        .int_rdata    (int_rdata),
        .ext_ds_n     (ext_ds_n),
        .ext_addr     (ext_addr),
        .ext_fc       (ext_fc),
        .ext_size     (ext_size),
        .ext_rnw      (ext_rnw),
        .ext_data_out (ext_data_out),
        .ext_data_oe  (ext_data_oe)
    );

    // Internal accesses never use the address strobe.
    assign ext_as_n = 1'b1;

    AST_OE_WITH_DS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_data_oe == !ext_ds_n); // R7
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (int_start && !ext_data_oe && cfg_rd_data == '0) |=> ext_ds_n); // R5
endmodule

// File: tb/show_cycle_ctrl_tb.sv
module show_cycle_ctrl_tb;
    localparam int AW = 32;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [1:0]    cfg_wr_data = '0;
    logic [1:0]    cfg_rd_data;
    logic          int_start = 1'b0;
    logic          int_end = 1'b0;
    logic [AW-1:0] int_addr = '0;
    logic [2:0]    int_fc = '0;
    logic [1:0]    int_size = '0;
    logic          int_rnw = 1'b0;
    logic [DW-1:0] int_wdata = '0;
    logic [DW-1:0] int_rdata = '0;
    logic          ext_as_n, ext_ds_n, ext_rnw, ext_data_oe;
    logic [AW-1:0] ext_addr;
    logic [2:0]    ext_fc;
    logic [1:0]    ext_size;
    logic [DW-1:0] ext_data_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;   // 250 MHz

    show_cycle_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .int_start(int_start), .int_end(int_end), .int_addr(int_addr),
        .int_fc(int_fc), .int_size(int_size), .int_rnw(int_rnw),
        .int_wdata(int_wdata), .int_rdata(int_rdata),
        .ext_as_n(ext_as_n), .ext_ds_n(ext_ds_n), .ext_addr(ext_addr),
        .ext_fc(ext_fc), .ext_size(ext_size), .ext_rnw(ext_rnw),
        .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe)
    );

    typedef struct {
        string         req;
        logic          as_n, ds_n, oe, rnw;
        logic [DW-1:0] data;
        logic [AW-1:0] addr;
        logic [2:0]    fc;
        logic [1:0]    size, cfg;
    } exp_t;

    exp_t sb_q[$];

    // Reference state built from the requirements.
    int            m_state = 0;   // 0 idle, 1 mirrored, 2 hidden
    logic          m_last = 1'b0;
    logic [1:0]    m_cfg = '0;
    logic [AW-1:0] m_addr = '0;
    logic [2:0]    m_fc = '0;
    logic [1:0]    m_size = '0;
    logic          m_rnw = 1'b0;
    logic [DW-1:0] m_data = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: apply one clock of stimulus and queue the outputs expected after it.
    task automatic drive(logic st, logic en, logic [AW-1:0] a, logic [2:0] fc,
                         logic [1:0] sz, logic rnw, logic [DW-1:0] wd,
                         logic [DW-1:0] rd, logic we, logic [1:0] cw, string req);
        exp_t e;
        logic [1:0] cfg_old;
        @(negedge clk);
        int_start = st; int_end = en; int_addr = a; int_fc = fc; int_size = sz;
        int_rnw = rnw; int_wdata = wd; int_rdata = rd;
        cfg_wr_en = we; cfg_wr_data = cw;
        cfg_old = m_cfg;
        if (we) m_cfg = cw;
        if (m_state == 0) begin
            if (st) begin
                m_state = (cfg_old != 2'b00) ? 1 : 2;
                m_last = en;
                m_addr = a; m_fc = fc; m_size = sz; m_rnw = rnw;
                m_data = rnw ? rd : wd;
            end
        end else begin
            if (m_rnw) m_data = rd;
            if (en || m_last) begin
                m_state = 0;
                m_last = 1'b0;
            end
        end
        e.req = req; e.as_n = 1'b1;
        e.ds_n = (m_state != 1); e.oe = (m_state == 1);
        e.data = (m_state == 1) ? m_data : '0;
        e.addr = m_addr; e.fc = m_fc; e.size = m_size; e.rnw = m_rnw; e.cfg = m_cfg;
        sb_q.push_back(e);
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++)
            drive(1'b0, 1'b0, 32'h5A00_0000 + i, 3'd7, 2'd3, 1'b1, 16'hBEEF, 16'hC0DE + i,
                  1'b0, 2'b00, req);
    endtask

    task automatic wcfg(logic [1:0] v, string req);
        drive(1'b0, 1'b0, 32'h0, 3'd0, 2'd0, 1'b0, 16'h0, 16'h0, 1'b1, v, req);
    endtask

    // Monitor: compare outputs one time unit after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.req, "ext_as_n", ext_as_n, e.as_n);
            chk(e.req, "ext_ds_n", ext_ds_n, e.ds_n);
            chk(e.req, "ext_data_oe", ext_data_oe, e.oe);
            chk(e.req, "ext_data_out", ext_data_out, e.data);
            chk(e.req, "ext_addr", ext_addr, e.addr);
            chk(e.req, "ext_fc", ext_fc, e.fc);
            chk(e.req, "ext_size", ext_size, e.size);
            chk(e.req, "ext_rnw", ext_rnw, e.rnw);
            chk(e.req, "cfg_rd_data", cfg_rd_data, e.cfg);
        end
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "cfg_rd_data", cfg_rd_data, 0);
        chk("R1", "ext_as_n", ext_as_n, 1);
        chk("R1", "ext_ds_n", ext_ds_n, 1);
        chk("R1", "ext_data_oe", ext_data_oe, 0);
        chk("R1", "ext_data_out", ext_data_out, 0);
        chk("R1", "ext_addr", ext_addr, 0);
        rst_n = 1'b1;
        idle(1, "R1");

        // R2: field write and readback
        wcfg(2'b10, "R2");
        wcfg(2'b00, "R2");

        // R5 / R3 / R4: hidden write access, attributes still mirrored
        drive(1'b1, 1'b0, 32'h0000_1000, 3'd5, 2'd1, 1'b0, 16'hA5A5, 16'h0, 1'b0, 2'b00, "R5");
        drive(1'b0, 1'b0, 32'h2222_2222, 3'd2, 2'd0, 1'b1, 16'h1111, 16'h0, 1'b0, 2'b00, "R3");
        drive(1'b0, 1'b1, 32'h3333_3333, 3'd1, 2'd2, 1'b0, 16'h2222, 16'h0, 1'b0, 2'b00, "R5");
        idle(2, "R4");

        // R6 / R8 / R7: mirrored write with field 01
        wcfg(2'b01, "R2");
        drive(1'b1, 1'b0, 32'h0000_3000, 3'd1, 2'd2, 1'b0, 16'h1234, 16'h0, 1'b0, 2'b00, "R6");
        drive(1'b0, 1'b0, 32'h0, 3'd0, 2'd0, 1'b0, 16'hFFFF, 16'h9999, 1'b0, 2'b00, "R8");
        drive(1'b0, 1'b0, 32'h0, 3'd0, 2'd0, 1'b0, 16'h0F0F, 16'h9999, 1'b0, 2'b00, "R7");
        drive(1'b0, 1'b1, 32'h0, 3'd0, 2'd0, 1'b0, 16'h0F0F, 16'h9999, 1'b0, 2'b00, "R6");
        idle(1, "R6");

        // R9: mirrored read with field 11, read data changing
        wcfg(2'b11, "R2");
        drive(1'b1, 1'b0, 32'h0000_4000, 3'd6, 2'd1, 1'b1, 16'h0, 16'h0101, 1'b0, 2'b00, "R9");
        drive(1'b0, 1'b0, 32'h0, 3'd0, 2'd0, 1'b0, 16'h0, 16'h0202, 1'b0, 2'b00, "R9");
        drive(1'b0, 1'b0, 32'h0, 3'd0, 2'd0, 1'b0, 16'h0, 16'h0303, 1'b0, 2'b00, "R9");
        drive(1'b0, 1'b1, 32'h0, 3'd0, 2'd0, 1'b0, 16'h0, 16'h0404, 1'b0, 2'b00, "R9");
        idle(1, "R9");

        // R10: field changes during an open access
        wcfg(2'b10, "R2");
        drive(1'b1, 1'b0, 32'h0000_5000, 3'd2, 2'd0, 1'b0, 16'h5555, 16'h0, 1'b0, 2'b00, "R10");
        wcfg(2'b00, "R10");
        drive(1'b0, 1'b1, 32'h0, 3'd0, 2'd0, 1'b0, 16'h0, 16'h0, 1'b0, 2'b00, "R10");
        drive(1'b1, 1'b0, 32'h0000_6000, 3'd3, 2'd1, 1'b0, 16'h6666, 16'h0, 1'b0, 2'b00, "R10");
        wcfg(2'b11, "R10");
        drive(1'b0, 1'b1, 32'h0, 3'd0, 2'd0, 1'b0, 16'h0, 16'h0, 1'b0, 2'b00, "R10");
        idle(1, "R10");

        // R11: start and end on the same clock
        drive(1'b1, 1'b1, 32'h0000_7000, 3'd4, 2'd2, 1'b0, 16'h7777, 16'h0, 1'b0, 2'b00, "R11");
        idle(2, "R11");

        // R12: start while an access is open is ignored
        drive(1'b1, 1'b0, 32'h0000_8000, 3'd5, 2'd1, 1'b0, 16'h8888, 16'h0, 1'b0, 2'b00, "R12");
        drive(1'b1, 1'b0, 32'h0000_9000, 3'd6, 2'd3, 1'b1, 16'h9999, 16'h0, 1'b0, 2'b00, "R12");
        drive(1'b0, 1'b1, 32'h0, 3'd0, 2'd0, 1'b0, 16'h0, 16'h0, 1'b0, 2'b00, "R12");
        idle(2, "R12");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule